// File: doc/BRIEF.md
# Max-Min Fair Share Allocator

This block divides a shared capacity among up to N requesters so that the result is max-min fair. Nobody receives more than it asked for. The smallest demands are met in full. Whatever they leave over is shared equally among the requesters that are still short. Demands, capacity and allocations are unsigned fixed-point numbers that all use the same binary point. The arithmetic does not depend on where that point sits, so the number of fractional bits is a property of the data and not of the hardware.

A client presents the demand vector and the capacity and pulses `start` while the block is idle. The block then repeats a progressive-filling round until no excess remains:

1. Divide the remaining capacity by the number of unsatisfied requesters, using a sequential divider.
2. Walk through the requesters. Each unsatisfied requester whose demand fits under that equal share is satisfied, and its demand is taken out of the remaining capacity.
3. If the walk satisfied anyone and someone is still unsatisfied, run another round.
4. If the walk satisfied nobody, every remaining requester receives the equal share.

When the sequence ends, `done` pulses for one cycle and the allocation vector stays stable until the next accepted `start`.

The controller has six named states:

| State | Role |
|---|---|
| IDLE | Waits for `start`. |
| LAUNCH | Issues a division. |
| DIVIDE | Waits for the quotient. |
| SCAN | Walks through the requesters, one per cycle. |
| FILL | Gives the equal share to every remaining requester. |
| DONE | Pulses `done`. |

The transitions are:

- IDLE→LAUNCH on `start` when some demand is nonzero.
- IDLE→DONE on `start` when every demand is zero.
- LAUNCH→DIVIDE always.
- DIVIDE→SCAN when the quotient is valid.
- SCAN→LAUNCH after the last requester, if the pass satisfied someone and some requester remains.
- SCAN→DONE after the last requester, if no requester remains.
- SCAN→FILL after the last requester, if the pass satisfied nobody.
- FILL→DONE always.
- DONE→IDLE always.

Top module: `mmf_alloc`

## Requirements
- R1: After reset, every allocation is 0 and both `busy` and `done` are 0.
- R2: No requester is ever allocated more than its own demand.
- R3: A requester with zero demand is allocated 0 and is not counted when the capacity is split. When all demands are zero, the block still completes with every allocation 0.
- R4: When the sum of the demands is at most the capacity, each requester is allocated exactly its demand.
- R5: When every demand is at least floor(capacity / number of nonzero demands), each nonzero requester is allocated exactly that floor.
- R6: Capacity left over by satisfied requesters goes equally to the unsatisfied ones. With 8 fractional bits, demands 512, 665, 1024 and 1280 (2, 2.6, 4 and 5) and capacity 2560 (10) yield 512, 665, 691 and 691.
- R7: Service follows increasing demand. A requester with a smaller demand never receives more than a requester with a larger demand.
- R8: Each unsatisfied requester receives floor(R/k), where R is the capacity left after the satisfied requesters and k is the number of unsatisfied requesters. The truncation remainder stays unallocated, so the allocations sum to at most the capacity. Every allocation is within one LSB of a sorted-order reference.
- R9: `start` is accepted only while `busy` is 0, and a `start` while busy has no effect. `done` is high for exactly one cycle. The allocations stay stable after `done` until the next accepted `start`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge. |
| rst_n | input | 1 | Asynchronous reset, active low. |
| start | input | 1 | Loads the demands and capacity and begins a run when the block is idle. |
| capacity | input | CW = W+clog2(N) | Total capacity to share. |
| demand | input | N*W | Demand of requester i in bits [i*W +: W]. |
| alloc | output | N*W | Allocation of requester i in bits [i*W +: W]. |
| busy | output | 1 | High from an accepted start until done. |
| done | output | 1 | One-cycle pulse when the allocations are final. |

## Verification
Several demand patterns are applied, and each one isolates a different exit of the filling sequence.

- **Under-subscribed vectors** end with every requester satisfied, and never reach FILL.
- **Uniformly large vectors** go straight to FILL after the first equal split.
- **The 2/2.6/4/5 case and a shuffled mixed vector** need several rounds of redistribution. They separate a correct redistribution from one that stops after the first round or that ignores the ordering by demand.
- **Zero demands, equal demands with an indivisible capacity, and a start pulse injected mid-run** show whether zero requesters are excluded from the count, whether the truncation remainder is handled correctly, and whether a start while busy is rejected.

// File: rtl/mmf_pkg.sv
package mmf_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LAUNCH,
        ST_DIVIDE,
        ST_SCAN,
        ST_FILL,
        ST_DONE
    } mmf_state_t;
endpackage

// File: rtl/mmf_divider.sv
// Restoring divider: quotient = dividend / divisor, one bit per cycle.
module mmf_divider #(
    parameter int DW = 18,
    parameter int SW = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          go,
    input  logic [DW-1:0] dividend,
    input  logic [SW-1:0] divisor,
    output logic          valid,
    output logic [DW-1:0] quotient
);
    localparam int CNTW = $clog2(DW + 1);
    localparam int PW   = DW + SW;

    logic [DW-1:0]   dq;
    logic [DW-1:0]   dvd_q;
    logic [SW-1:0]   rem;
    logic [SW-1:0]   dvs;
    logic [CNTW-1:0] cnt;
    logic            running;

    logic [SW:0]     shifted;
    logic [SW:0]     diff;
    logic            fits;

    always_comb begin
        shifted = {rem, dq[DW-1]};
        fits    = shifted >= {1'b0, dvs};
        diff    = shifted - {1'b0, dvs};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dq      <= '0;
            dvd_q   <= '0;
            rem     <= '0;
            dvs     <= '0;
            cnt     <= '0;
            running <= 1'b0;
            valid   <= 1'b0;
        end else if (go) begin
            dq      <= dividend;
            dvd_q   <= dividend;
            rem     <= '0;
            dvs     <= divisor;
            cnt     <= CNTW'(DW);
            running <= 1'b1;
            valid   <= 1'b0;
        end else if (running) begin
            rem     <= fits ? diff[SW-1:0] : shifted[SW-1:0];
            dq      <= {dq[DW-2:0], fits};
            cnt     <= cnt - 1'b1;
            running <= (cnt != CNTW'(1));
            valid   <= (cnt == CNTW'(1));
        end else begin
            valid   <= 1'b0;
        end
    end

    assign quotient = dq;

    logic [PW-1:0] prod;
    assign prod = PW'(dq) * PW'(dvs);

    AST_SHARE_IS_FLOOR: assert property (@(posedge clk) disable iff (!rst_n)
        (valid && dvs != '0) |-> (prod <= PW'(dvd_q) && prod + PW'(dvs) > PW'(dvd_q))); // R8
endmodule

// File: rtl/mmf_lane.sv
// Per-requester state: demand, allocation, unsatisfied flag.
module mmf_lane #(
    parameter int W  = 16,
    parameter int CW = 18
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [W-1:0]  demand_in,
    input  logic          take,
    input  logic          fill,
    input  logic [CW-1:0] share,
    output logic [W-1:0]  dem,
    output logic [W-1:0]  alloc,
    output logic          fits
);
    logic active;

    assign fits = active && (CW'(dem) <= share);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dem    <= '0;
            alloc  <= '0;
            active <= 1'b0;
        end else if (load) begin
            dem    <= demand_in;
            alloc  <= '0;
            active <= (demand_in != '0);
        end else if (take && fits) begin
            alloc  <= dem;
            active <= 1'b0;
        end else if (fill && active) begin
            alloc  <= share[W-1:0];
            active <= 1'b0;
        end
    end

    AST_ALLOC_CAPPED: assert property (@(posedge clk) disable iff (!rst_n)
        alloc <= dem); // R2
    AST_ZERO_LANE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (dem == '0) |-> (alloc == '0 && !active)); // R3
    AST_FILL_UNDER_DEMAND: assert property (@(posedge clk) disable iff (!rst_n)
        (fill && active) |-> (CW'(dem) > share)); // R8
endmodule

// File: rtl/mmf_alloc.sv
module mmf_alloc
    import mmf_pkg::*;
#(
    parameter int N = 4,
    parameter int W = 16
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       start,
    input  logic [W+$clog2(N)-1:0]     capacity,
    input  logic [N*W-1:0]             demand,
    output logic [N*W-1:0]             alloc,
    output logic                       busy,
    output logic                       done
);
    localparam int CW = W + $clog2(N);
    localparam int KW = $clog2(N + 1);
    localparam int IW = (N > 1) ? $clog2(N) : 1;

    mmf_state_t state, state_nx;

    logic [CW-1:0] resid;
    logic [KW-1:0] kact;
    logic [IW-1:0] idx;
    logic          any_take;

    logic          load, div_go, fill;
    logic [N-1:0]  take_v, fits_v;
    logic [W-1:0]  dem_a [N];
    logic          div_valid;
    logic [CW-1:0] share;
    logic [KW-1:0] nz_cnt;
    logic          sel_fits;
    logic [W-1:0]  sel_dem;
    logic          last_idx;
    logic [KW-1:0] k_after;

    always_comb begin
        nz_cnt = '0;
        for (int i = 0; i < N; i++)
            nz_cnt = nz_cnt + KW'(demand[i*W +: W] != '0);
    end

    assign sel_fits = fits_v[idx];
    assign sel_dem  = dem_a[idx];
    assign last_idx = (idx == IW'(N - 1));
    assign k_after  = kact - KW'(sel_fits);

    generate
        for (genvar g = 0; g < N; g++) begin : g_lane
            mmf_lane #(.W(W), .CW(CW)) u_lane (
                .clk       (clk),
                .rst_n     (rst_n),
                .load      (load),
                .demand_in (demand[g*W +: W]),
                .take      (take_v[g]),
                .fill      (fill),
                .share     (share),
                .dem       (dem_a[g]),
                .alloc     (alloc[g*W +: W]),
                .fits      (fits_v[g])
            );
        end
    endgenerate

    mmf_divider #(.DW(CW), .SW(KW)) u_div (
        .clk      (clk),
        .rst_n    (rst_n),
        .go       (div_go),
        .dividend (resid),
        .divisor  (kact),
        .valid    (div_valid),
        .quotient (share)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // Next state
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:   if (start) state_nx = (nz_cnt == '0) ? ST_DONE : ST_LAUNCH;
            ST_LAUNCH: state_nx = ST_DIVIDE;
            ST_DIVIDE: if (div_valid) state_nx = ST_SCAN;
            ST_SCAN:   if (last_idx) begin
                           if (!(any_take || sel_fits)) state_nx = ST_FILL;
                           else if (k_after == '0)      state_nx = ST_DONE;
                           else                         state_nx = ST_LAUNCH;
                       end
            ST_FILL:   state_nx = ST_DONE;
            ST_DONE:   state_nx = ST_IDLE;
            default:   state_nx = ST_IDLE;
        endcase
    end

    // Outputs
    always_comb begin
        load   = (state == ST_IDLE) && start;
        div_go = (state == ST_LAUNCH);
        fill   = (state == ST_FILL);
        busy   = (state != ST_IDLE);
        done   = (state == ST_DONE);
        for (int i = 0; i < N; i++)
            take_v[i] = (state == ST_SCAN) && (idx == IW'(i));
    end

    // Datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            resid    <= '0;
            kact     <= '0;
            idx      <= '0;
            any_take <= 1'b0;
        end else begin
            unique case (state)
                ST_IDLE: if (start) begin
                    resid <= capacity;
                    kact  <= nz_cnt;
                end
                ST_LAUNCH: begin
                    idx      <= '0;
                    any_take <= 1'b0;
                end
                ST_SCAN: begin
                    idx <= idx + 1'b1;
                    if (sel_fits) begin
                        resid    <= resid - CW'(sel_dem);
                        kact     <= k_after;
                        any_take <= 1'b1;
                    end
                end
                default: ;
            endcase
        end
    end

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R9
    AST_RESID_NO_GROWTH: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_IDLE) |=> (resid <= $past(resid))); // R8
    AST_FILL_HAS_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_FILL) |-> (kact != '0)); // R8
    AST_DIV_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
        div_go |-> (kact != '0)); // R3
endmodule

// File: tb/tb_mmf_alloc.sv
module tb_mmf_alloc;
    localparam int N    = 4;
    localparam int W    = 16;
    localparam int CW   = W + $clog2(N);
    localparam int FRAC = 8;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            start = 1'b0;
    logic [CW-1:0]   capacity = '0;
    logic [N*W-1:0]  demand = '0;
    logic [N*W-1:0]  alloc;
    logic            busy, done;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;

    always #4 clk = ~clk;

    mmf_alloc #(.N(N), .W(W)) dut (
        .clk(clk), .rst_n(rst_n), .start(start), .capacity(capacity),
        .demand(demand), .alloc(alloc), .busy(busy), .done(done)
    );

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            fails++;
            $display("FAIL watchdog: actual=hung expected=finish");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    function automatic int get_a(int i);
        return int'(alloc[i*W +: W]);
    endfunction

    task automatic chk(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Sorted-order reference: visit demands smallest first.
    task automatic ref_alloc(input int cap, input int d[N], output int a[N]);
        int ord[N];
        int rem, left, sh;
        bit filled;
        for (int i = 0; i < N; i++) begin ord[i] = i; a[i] = 0; end
        for (int i = 0; i < N; i++)
            for (int j = 0; j < N - 1 - i; j++)
                if (d[ord[j]] > d[ord[j+1]]) begin
                    int t = ord[j]; ord[j] = ord[j+1]; ord[j+1] = t;
                end
        rem = cap; left = 0; filled = 0; sh = 0;
        for (int i = 0; i < N; i++) if (d[i] != 0) left++;
        for (int p = 0; p < N; p++) begin
            int k = ord[p];
            if (d[k] == 0) continue;
            if (filled) a[k] = sh;
            else if (d[k] <= rem / left) begin
                a[k] = d[k]; rem -= d[k]; left--;
            end else begin
                sh = rem / left; filled = 1; a[k] = sh;
            end
        end
    endtask

    task automatic launch(input int cap, input int d[N]);
        @(negedge clk);
        capacity = CW'(cap);
        for (int i = 0; i < N; i++) demand[i*W +: W] = W'(d[i]);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic wait_done();
        int n = 0;
        while (!done && n < 5000) begin @(negedge clk); n++; end
        chk("R9 done seen", int'(done), 1);
    endtask

    task automatic check_result(string tag, input int cap, input int d[N]);
        int r[N];
        int sum = 0;
        ref_alloc(cap, d, r);
        for (int i = 0; i < N; i++) begin
            int df = get_a(i) - r[i];
            checks++;
            if (df > 1 || df < -1) begin
                fails++;
                $display("FAIL R8 %s lane %0d: actual=%0d expected=%0d", tag, i, get_a(i), r[i]);
            end
            if (get_a(i) > d[i]) chk({"R2 ", tag}, get_a(i), d[i]);
            sum += get_a(i);
        end
        chk({"R8 sum within capacity ", tag}, int'(sum <= cap), 1);
        for (int i = 0; i < N; i++)
            for (int j = 0; j < N; j++)
                if (d[i] < d[j] && get_a(i) > get_a(j))
                    chk({"R7 ordering ", tag}, get_a(i), get_a(j));
        @(negedge clk);
        chk({"R9 done one cycle ", tag}, int'(done), 0);
    endtask

    task automatic run(string tag, input int cap, input int d[N]);
        launch(cap, d);
        wait_done();
        check_result(tag, cap, d);
    endtask

    task automatic t_reset();
        for (int i = 0; i < N; i++) chk("R1 alloc", get_a(i), 0);
        chk("R1 busy", int'(busy), 0);
        chk("R1 done", int'(done), 0);
    endtask

    task automatic t_example();
        int d[N] = '{2 << FRAC, 665, 4 << FRAC, 5 << FRAC};
        run("example", 10 << FRAC, d);
        chk("R6 a0", get_a(0), 512);
        chk("R6 a1", get_a(1), 665);
        chk("R6 a2", get_a(2), 691);
        chk("R6 a3", get_a(3), 691);
    endtask

    task automatic t_fits();
        int d[N] = '{100, 200, 300, 400};
        run("undersubscribed", 2000, d);
        for (int i = 0; i < N; i++) chk("R4 exact demand", get_a(i), d[i]);
    endtask

    task automatic t_equal();
        int d[N] = '{3000, 4000, 5000, 6000};
        run("equal split", 1000, d);
        for (int i = 0; i < N; i++) chk("R5 first split", get_a(i), 250);
    endtask

    task automatic t_zero();
        int d[N] = '{0, 900, 0, 900};
        int z[N] = '{0, 0, 0, 0};
        run("zeros", 1000, d);
        chk("R3 zero lane0", get_a(0), 0);
        chk("R3 share lane1", get_a(1), 500);
        chk("R3 zero lane2", get_a(2), 0);
        chk("R3 share lane3", get_a(3), 500);
        run("all zero", 500, z);
        for (int i = 0; i < N; i++) chk("R3 all zero", get_a(i), 0);
    endtask

    task automatic t_mixed();
        int d[N] = '{5000, 10, 700, 300};
        run("mixed order", 1500, d);
        chk("R7 a0", get_a(0), 595);
        chk("R7 a1", get_a(1), 10);
        chk("R7 a2", get_a(2), 595);
        chk("R7 a3", get_a(3), 300);
    endtask

    task automatic t_trunc();
        int d[N] = '{7, 7, 7, 7};
        run("truncation", 10, d);
        for (int i = 0; i < N; i++) chk("R8 floor share", get_a(i), 2);
    endtask

    task automatic t_busy_start();
        int d[N] = '{3000, 3000, 3000, 3000};
        launch(1000, d);
        repeat (5) @(negedge clk);
        chk("R9 busy", int'(busy), 1);
        capacity = CW'(4);
        for (int i = 0; i < N; i++) demand[i*W +: W] = W'(1);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        wait_done();
        for (int i = 0; i < N; i++) chk("R9 start ignored while busy", get_a(i), 250);
        repeat (10) @(negedge clk);
        for (int i = 0; i < N; i++) chk("R9 held after done", get_a(i), 250);
        chk("R9 idle", int'(busy), 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_example();
        t_fits();
        t_equal();
        t_zero();
        t_mixed();
        t_trunc();
        t_busy_start();
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule